// File: doc/BRIEF.md
# Sample-Depth Adapter Control Register Bank

This block is the register file that sits beside a streaming video sample-depth adapter. Software reaches it over a simple 32-bit bus. The bus uses a word address, a one-cycle write and a read whose data returns exactly one cycle after the request. The bank holds constant identification and build-parameter words. It also keeps a copy of the fields of the most recent image header packet, which an external parser delivers as parallel inputs with a load strobe. Software can read that copy back when the debug build option is enabled.

The output sample depth is double-buffered. A write to the depth register only stages the new value and raises a pending flag. A write of any value to the commit register arms the update. The staged value becomes active on the first field-start strobe that follows the commit, and the pending flag clears at that moment. The active depth drives the adapter directly, along with the same value minus one for outgoing header packets. A status word always reports whether a field is in progress and whether an update is still pending. All control and status pins are plain level or strobe signals; the block has no streaming interface and applies no back-pressure.

Top module: `depth_adapter_regs`

## Requirements
- R1: After reset, field_busy and update_pending are 0, bus_rvalid is 0, and depth_active equals the IN_BPC parameter.
- R2: A read request (bus_rd high in cycle n) produces bus_rvalid high in cycle n+1 with the data. Word address 0 always returns 0x6AF7024C: the upper half is a vendor code 0x6AF7 and the lower half a product code 0x024C.
- R3: Word addresses 1 to 5 return, in that order, the VERSION parameter, LITE as 0/1, DEBUG as 0/1, IN_BPC and OUT_BPC.
- R4: Each hdr_valid strobe captures the header inputs. The capture words are:
  - word 72 returns width as hdr_width_m1 + 1, in 17 bits;
  - word 73 returns height as hdr_height_m1 + 1, in 17 bits;
  - words 74, 76, 77, 78 and 79 return the interlace code (4 bits), colour space (7 bits), subsampling (2 bits), siting (2 bits) and field count (7 bits), zero-extended.
- R5: With DEBUG = 0, the capture words (72 to 79) and the depth word (82) read 0, while the status word (80) still reads the live status.
- R6: field_busy goes to 1 the cycle after field_start and to 0 the cycle after field_end. When both strobes occur in the same cycle, start wins.
- R7: A write to word 82 stores bits [4:0] as the staged depth, which word 82 reads back. The same write sets update_pending on the next cycle. Word 80 reports bit0 = field_busy and bit1 = update_pending.
- R8: The staged depth is copied to depth_active, and update_pending clears, only on a field_start that comes strictly after a write to commit word 81. Neither a boundary without a commit nor a commit without a boundary changes depth_active. A commit in the same cycle as field_start waits for the next field_start.
- R9: A depth write after a commit but before the boundary keeps update_pending set. The boundary then applies the latest staged value.
- R10: hdr_depth_m1 always equals depth_active minus one.
- R11: Unused and reserved words (6 to 71, 75, and above 82) read 0. Writes to any address other than words 81 and 82 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read request |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| hdr_valid | input | 1 | Header fields below are valid (capture strobe) |
| hdr_width_m1 | input | 16 | Header width minus one |
| hdr_height_m1 | input | 16 | Header height minus one |
| hdr_ilace | input | 4 | Header interlace code |
| hdr_cspace | input | 7 | Header colour space code |
| hdr_subs | input | 2 | Header subsampling code |
| hdr_cosite | input | 2 | Header chroma siting code |
| hdr_fcount | input | 7 | Header field count |
| field_start | input | 1 | Field start strobe (field boundary) |
| field_end | input | 1 | Field end strobe |
| field_busy | output | 1 | A field is in progress |
| update_pending | output | 1 | A staged depth has not yet been applied |
| depth_active | output | DEPTH_W | Active output bits per colour |
| hdr_depth_m1 | output | DEPTH_W | Active depth minus one, for outgoing headers |

## Verification
The assertions check the following on every cycle:
- read data arrives exactly one cycle after each request;
- a depth write raises the pending flag;
- depth_active never moves outside a field-start cycle;
- an armed boundary clears the pending flag;
- the busy flag follows the two strobes;
- a capture strobe loads the header copy.

Some behaviour can only be shown by the bench's ordered scenarios. These cover:
- a commit that lands in the same cycle as a boundary;
- a restage between commit and boundary that must win;
- the width readback at 0xFFFF + 1;
- the build with debug readback turned off.

// File: rtl/depth_regs_pkg.sv
package depth_regs_pkg;
  localparam logic [31:0] ID_WORD = 32'h6AF7_024C;

  localparam int W_ID      = 0;
  localparam int W_VERSION = 1;
  localparam int W_LITE    = 2;
  localparam int W_DEBUG   = 3;
  localparam int W_BPC_IN  = 4;
  localparam int W_BPC_OUT = 5;
  localparam int W_WIDTH   = 72;
  localparam int W_HEIGHT  = 73;
  localparam int W_ILACE   = 74;
  localparam int W_CSPACE  = 76;
  localparam int W_SUBS    = 77;
  localparam int W_COSITE  = 78;
  localparam int W_FCOUNT  = 79;
  localparam int W_STATUS  = 80;
  localparam int W_COMMIT  = 81;
  localparam int W_DEPTH   = 82;

  typedef struct packed {
    logic [15:0] width_m1;
    logic [15:0] height_m1;
    logic [3:0]  ilace;
    logic [6:0]  cspace;
    logic [1:0]  subs;
    logic [1:0]  cosite;
    logic [6:0]  fcount;
  } hdr_fields_t;
endpackage

// File: rtl/hdr_capture.sv
module hdr_capture
  import depth_regs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  hdr_fields_t fields_in,
  output hdr_fields_t fields_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) fields_q <= '0;
    else if (load) fields_q <= fields_in;
  end

  assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> fields_q == $past(fields_in));
endmodule

// File: rtl/field_tracker.sv
module field_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic start_pulse,
  input  logic end_pulse,
  output logic busy
);
  always_ff @(posedge clk) begin
    if (!rst_n) busy <= 1'b0;
    else if (start_pulse) busy <= 1'b1;
    else if (end_pulse) busy <= 1'b0;
  end

  assert_busy_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> busy);
  assert_busy_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (end_pulse && !start_pulse) |=> !busy);
endmodule

// File: rtl/depth_shadow.sv
module depth_shadow #(
  parameter int DEPTH_W   = 5,
  parameter int RESET_VAL = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stage_we,
  input  logic [DEPTH_W-1:0] stage_val,
  input  logic               commit,
  input  logic               boundary,
  output logic [DEPTH_W-1:0] staged,
  output logic [DEPTH_W-1:0] active,
  output logic               pending
);
  localparam logic [DEPTH_W-1:0] INIT = DEPTH_W'(RESET_VAL);

  logic armed;
  logic apply;

  assign apply = boundary && armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      staged  <= INIT;
      active  <= INIT;
      pending <= 1'b0;
      armed   <= 1'b0;
    end else begin
      if (apply) active <= staged;
      if (stage_we) staged <= stage_val;
      if (stage_we) pending <= 1'b1;
      else if (apply) pending <= 1'b0;
      if (commit) armed <= 1'b1;
      else if (boundary) armed <= 1'b0;
    end
  end

  assert_pending_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stage_we |=> pending);
  assert_active_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(active));
  assert_pending_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && !stage_we) |=> !pending);
  assert_restage_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && stage_we) |=> pending);
endmodule

// File: rtl/depth_adapter_regs.sv
module depth_adapter_regs
  import depth_regs_pkg::*;
#(
  parameter int          ADDR_W  = 7,
  parameter int          DATA_W  = 32,
  parameter int          DEPTH_W = 5,
  parameter int          IN_BPC  = 10,
  parameter int          OUT_BPC = 8,
  parameter logic [31:0] VERSION = 32'h0103_0002,
  parameter int          LITE    = 0,
  parameter int          DEBUG   = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               bus_rvalid,
  input  logic               hdr_valid,
  input  logic [15:0]        hdr_width_m1,
  input  logic [15:0]        hdr_height_m1,
  input  logic [3:0]         hdr_ilace,
  input  logic [6:0]         hdr_cspace,
  input  logic [1:0]         hdr_subs,
  input  logic [1:0]         hdr_cosite,
  input  logic [6:0]         hdr_fcount,
  input  logic               field_start,
  input  logic               field_end,
  output logic               field_busy,
  output logic               update_pending,
  output logic [DEPTH_W-1:0] depth_active,
  output logic [DEPTH_W-1:0] hdr_depth_m1
);
  localparam logic DBG_ON = (DEBUG != 0);
  localparam logic LITE_ON = (LITE != 0);

  hdr_fields_t hdr_in, hdr_q;
  logic wr_depth, wr_commit;
  logic [DEPTH_W-1:0] staged;
  logic [DATA_W-1:0] rd_mux;
  logic unused_wbits;

  assign hdr_in = '{width_m1: hdr_width_m1, height_m1: hdr_height_m1,
                    ilace: hdr_ilace, cspace: hdr_cspace, subs: hdr_subs,
                    cosite: hdr_cosite, fcount: hdr_fcount};

  assign wr_depth  = bus_wr && (bus_addr == ADDR_W'(W_DEPTH));
  assign wr_commit = bus_wr && (bus_addr == ADDR_W'(W_COMMIT));
  assign unused_wbits = ^bus_wdata[DATA_W-1:DEPTH_W];

  hdr_capture u_cap (
    .clk(clk), .rst_n(rst_n), .load(hdr_valid),
    .fields_in(hdr_in), .fields_q(hdr_q)
  );

  field_tracker u_fld (
    .clk(clk), .rst_n(rst_n), .start_pulse(field_start),
    .end_pulse(field_end), .busy(field_busy)
  );

  depth_shadow #(.DEPTH_W(DEPTH_W), .RESET_VAL(IN_BPC)) u_shd (
    .clk(clk), .rst_n(rst_n), .stage_we(wr_depth),
    .stage_val(bus_wdata[DEPTH_W-1:0]), .commit(wr_commit),
    .boundary(field_start), .staged(staged), .active(depth_active),
    .pending(update_pending)
  );

  assign hdr_depth_m1 = depth_active - DEPTH_W'(1);

  always_comb begin
    rd_mux = '0;
    case (int'(bus_addr))
      W_ID:      rd_mux = DATA_W'(ID_WORD);
      W_VERSION: rd_mux = DATA_W'(VERSION);
      W_LITE:    rd_mux = DATA_W'(LITE_ON);
      W_DEBUG:   rd_mux = DATA_W'(DBG_ON);
      W_BPC_IN:  rd_mux = DATA_W'(IN_BPC);
      W_BPC_OUT: rd_mux = DATA_W'(OUT_BPC);
      W_STATUS:  rd_mux = DATA_W'({update_pending, field_busy});
      default:   rd_mux = '0;
    endcase
    if (DBG_ON) begin
      case (int'(bus_addr))
        W_WIDTH:  rd_mux = DATA_W'({1'b0, hdr_q.width_m1} + 17'd1);
        W_HEIGHT: rd_mux = DATA_W'({1'b0, hdr_q.height_m1} + 17'd1);
        W_ILACE:  rd_mux = DATA_W'(hdr_q.ilace);
        W_CSPACE: rd_mux = DATA_W'(hdr_q.cspace);
        W_SUBS:   rd_mux = DATA_W'(hdr_q.subs);
        W_COSITE: rd_mux = DATA_W'(hdr_q.cosite);
        W_FCOUNT: rd_mux = DATA_W'(hdr_q.fcount);
        W_DEPTH:  rd_mux = DATA_W'(staged);
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  assert_rvalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);
  assert_no_rvalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);
  assert_id_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == '0) |=> bus_rdata == DATA_W'(ID_WORD));
  assert_hdr_depth_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(depth_active) |-> hdr_depth_m1 + DEPTH_W'(1) == depth_active);
endmodule

// File: tb/sim_depth_adapter_regs.sv
module sim_depth_adapter_regs;
  localparam logic [31:0] VER = 32'h0103_0002;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [6:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] rdata0, rdata1;
  logic rvalid0, rvalid1;
  logic hdr_valid = 0;
  logic [15:0] w_m1 = 0, h_m1 = 0;
  logic [3:0] ilace = 0;
  logic [6:0] cspace = 0, fcount = 0;
  logic [1:0] subs = 0, cosite = 0;
  logic fs = 0, fe = 0;
  logic busy0, pend0, busy1, pend1;
  logic [4:0] act0, m10, act1, m11;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  depth_adapter_regs #(.VERSION(VER)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata0),
    .bus_rvalid(rvalid0), .hdr_valid(hdr_valid), .hdr_width_m1(w_m1),
    .hdr_height_m1(h_m1), .hdr_ilace(ilace), .hdr_cspace(cspace),
    .hdr_subs(subs), .hdr_cosite(cosite), .hdr_fcount(fcount),
    .field_start(fs), .field_end(fe), .field_busy(busy0),
    .update_pending(pend0), .depth_active(act0), .hdr_depth_m1(m10));

  depth_adapter_regs #(.VERSION(VER), .DEBUG(0)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata1),
    .bus_rvalid(rvalid1), .hdr_valid(hdr_valid), .hdr_width_m1(w_m1),
    .hdr_height_m1(h_m1), .hdr_ilace(ilace), .hdr_cspace(cspace),
    .hdr_subs(subs), .hdr_cosite(cosite), .hdr_fcount(fcount),
    .field_start(fs), .field_end(fe), .field_busy(busy1),
    .update_pending(pend1), .depth_active(act1), .hdr_depth_m1(m11));

  // behavioural reference model
  bit m_busy, m_pend, m_armed, m_rvalid;
  int m_staged, m_active, m_rdata;
  int c_w, c_h, c_il, c_cs, c_sb, c_co, c_fc;

  function automatic int model_read(int a);
    case (a)
      0: return 32'h6AF7024C;
      1: return VER;
      2: return 0;
      3: return 1;
      4: return 10;
      5: return 8;
      72: return c_w + 1;
      73: return c_h + 1;
      74: return c_il;
      76: return c_cs;
      77: return c_sb;
      78: return c_co;
      79: return c_fc;
      80: return m_pend * 2 + m_busy;
      82: return m_staged;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    bit apply;
    if (!rst_n) begin
      m_busy = 0; m_pend = 0; m_armed = 0; m_rvalid = 0;
      m_staged = 10; m_active = 10; m_rdata = 0;
      c_w = 0; c_h = 0; c_il = 0; c_cs = 0; c_sb = 0; c_co = 0; c_fc = 0;
    end else begin
      m_rvalid = bus_rd;
      if (bus_rd) m_rdata = model_read(int'(bus_addr));
      apply = fs && m_armed;
      if (apply) m_active = m_staged;
      if (bus_wr && bus_addr == 82) begin
        m_staged = int'(bus_wdata[4:0]); m_pend = 1;
      end else if (apply) m_pend = 0;
      if (bus_wr && bus_addr == 81) m_armed = 1;
      else if (fs) m_armed = 0;
      if (fs) m_busy = 1; else if (fe) m_busy = 0;
      if (hdr_valid) begin
        c_w = int'(w_m1); c_h = int'(h_m1); c_il = int'(ilace);
        c_cs = int'(cspace); c_sb = int'(subs); c_co = int'(cosite); c_fc = int'(fcount);
      end
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R6 busy", busy0, m_busy);
    chk("R7/R8/R9 pending", pend0, m_pend);
    chk("R8 active depth", act0, m_active);
    chk("R10 header depth", m10, 5'(m_active - 1));
    chk("R2 rvalid", rvalid0, m_rvalid);
    if (m_rvalid) chk("R2/R3/R4/R11 read data", rdata0, 32'(m_rdata));
  end

  task automatic cyc(); @(negedge clk); endtask

  task automatic wr(int a, int d);
    cyc(); bus_wr = 1; bus_addr = 7'(a); bus_wdata = 32'(d);
    cyc(); bus_wr = 0;
  endtask

  task automatic rd(int a, output logic [31:0] d0, output logic [31:0] d1);
    cyc(); bus_rd = 1; bus_addr = 7'(a);
    cyc(); bus_rd = 0; d0 = rdata0; d1 = rdata1;
  endtask

  task automatic pulse_start(); cyc(); fs = 1; cyc(); fs = 0; endtask
  task automatic pulse_end();   cyc(); fe = 1; cyc(); fe = 0; endtask

  task automatic hdr(int w, int h, int il, int cs, int sb, int co, int fc);
    cyc(); hdr_valid = 1; w_m1 = 16'(w); h_m1 = 16'(h); ilace = 4'(il);
    cspace = 7'(cs); subs = 2'(sb); cosite = 2'(co); fcount = 7'(fc);
    cyc(); hdr_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d0, d1;
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    chk("R1 busy reset", busy0, 0);
    chk("R1 pending reset", pend0, 0);
    chk("R1 rvalid reset", rvalid0, 0);
    chk("R1 depth reset", act0, 10);

    rd(0, d0, d1); chk("R2 id word", d0, 32'h6AF7024C);
    rd(1, d0, d1); chk("R3 version", d0, VER);
    rd(3, d0, d1); chk("R3 debug flag", d0, 1);
    rd(3, d0, d1); chk("R3 debug flag off", d1, 0);
    rd(4, d0, d1); chk("R3 input bpc", d0, 10);
    rd(5, d0, d1); chk("R3 output bpc", d0, 8);
    rd(6, d0, d1); chk("R11 unused", d0, 0);
    rd(75, d0, d1); chk("R11 reserved", d0, 0);
    rd(100, d0, d1); chk("R11 above map", d0, 0);
    wr(0, 32'h1234); wr(75, 5); wr(80, 3);
    rd(0, d0, d1); chk("R11 ro write ignored", d0, 32'h6AF7024C);
    chk("R11 no pending from ro write", pend0, 0);

    hdr(1919, 1079, 3, 5, 2, 1, 77);
    rd(72, d0, d1); chk("R4 width", d0, 1920);
    rd(73, d0, d1); chk("R4 height", d0, 1080);
    rd(79, d0, d1); chk("R4 field count", d0, 77);
    hdr(16'hFFFF, 0, 0, 0, 0, 0, 0);
    rd(72, d0, d1); chk("R4 width max", d0, 65536);
    rd(73, d0, d1); chk("R4 height min", d0, 1);

    pulse_start(); chk("R6 busy after start", busy0, 1);
    pulse_end();   chk("R6 idle after end", busy0, 0);
    cyc(); fs = 1; fe = 1; cyc(); fs = 0; fe = 0;
    chk("R6 start wins", busy0, 1);

    wr(82, 12); chk("R7 pending set", pend0, 1);
    rd(82, d0, d1); chk("R7 staged readback", d0, 12);
    pulse_start(); chk("R8 no commit no apply", act0, 10);
    wr(81, 0); cyc(); chk("R8 commit alone no apply", act0, 10);
    pulse_start(); chk("R8 applied", act0, 12);
    chk("R8 pending cleared", pend0, 0);
    chk("R10 header depth", m10, 11);

    wr(82, 6); wr(81, 0); wr(82, 9);
    chk("R9 pending held", pend0, 1);
    pulse_start(); chk("R9 latest applied", act0, 9);
    chk("R9 pending cleared", pend0, 0);

    wr(82, 16);
    cyc(); bus_wr = 1; bus_addr = 81; fs = 1;
    cyc(); bus_wr = 0; fs = 0;
    chk("R8 same-cycle commit waits", act0, 9);
    pulse_start(); chk("R8 next boundary applies", act0, 16);

    wr(82, 20);
    rd(72, d0, d1); chk("R5 gated width", d1, 0);
    rd(82, d0, d1); chk("R5 gated depth", d1, 0);
    rd(80, d0, d1); chk("R5 status live", d1, {30'd0, pend1, busy1});
    chk("R5 status value", d1, 3);

    repeat (3) cyc();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule